// File: doc/BRIEF.md
# BCD clock calendar counter

This block keeps time of day and a calendar for a low-rate timekeeping subsystem. A 64 Hz tick drives a prescaler that emits one increment per second. The increment ripples through seconds, minutes, hours, day of month, weekday, month and a two-digit year. All fields except the weekday are kept in BCD. The day counter respects the length of each month, adds a 29th day to February in every year whose two-digit value is a multiple of four (00 included), and flips a century bit when the year passes from 99 to 00.

Software reaches the fields through a byte-wide register port with a write strobe and a separate combinational read address. While a bus access is in progress the counters hold still, so a multi-byte read never sees a carry half applied. Increments that come due during that window are counted and applied once the access ends. A sticky supply-low flag is set from an input pin and cleared only by a write. A prescaler stop input parks the prescaler at zero, which makes the first second after release arrive after half a period.

Top module: `rtcc_clock_calendar`

## Requirements
- R1: After reset the readable registers hold: seconds register 0x80 (supply-low flag set, seconds 00), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month register 0x01 (century bit clear), year 0x00.
- R2: With the prescaler running, the seconds field advances by exactly one for every 64 ticks on `tick_in`.
- R3: While `presc_stop` is high the prescaler is held at zero and no second is produced. After it falls, the first second comes on the 32nd tick and not on the 31st.
- R4: Seconds and minutes count in BCD from 00 to 59. Passing 59 returns the field to 00 and carries into the next field.
- R5: Hours count in BCD from 00 to 23. Passing 23 returns hours to 00 and advances the day and the weekday.
- R6: Weekday is binary (bits 2:0 of register 4), counts 0 to 6 and wraps from 6 to 0.
- R7: Day counts from 01 up to the month length: 31 for months 01, 03, 05, 07, 08, 10, 12 and 30 for months 04, 06, 09, 11. It then returns to 01 and the month advances.
- R8: February ends at day 29 when the BCD year is a multiple of four, including 00, and at day 28 otherwise.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and toggles the century bit, which is bit 7 of the month register.
- R10: The supply-low flag (bit 7 of the seconds register) is set by a one-cycle pulse on `supply_low`. It stays set through other writes and clears only when the seconds register is written with bit 7 at 0.
- R11: While `access_busy` is high no readable field changes from counting. A second that falls due during the access is applied after `access_busy` falls.
- R12: A write loads the addressed register. The address map is 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year. Bits that are not implemented read as zero (minutes bit 7, hours and day bits 7:6, weekday bits 7:3, month bits 6:5). Address 7 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle pulse per 64 Hz tick |
| presc_stop | input | 1 | Holds the prescaler at zero while high |
| supply_low | input | 1 | Supply-low indication; sets the sticky flag |
| access_busy | input | 1 | High while a bus access is in progress; freezes counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for reads |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |

## Verification
Every cycle, the assertions check several properties. A stop request is never followed by a second on the next cycle. Nothing counts while an access is in progress. The supply-low flag never drops except on a seconds write. The seconds field returns to 00 after 59. The century bit flips on every carry out of year 99. The pending-increment counter never saturates. The bench scenarios are needed for the calendar arithmetic: month lengths, the leap rule on both even and odd tens digits, the exact 32 and 64 tick spacing, catch-up after a freeze, and the masking of unimplemented bits, because each of these depends on a specific written state and a specific sequence of ticks.

// File: rtl/rtcc_pkg.sv
// Package for the clock calendar: register address map and BCD helpers.
// Assumes BCD inputs are well formed (each nibble 0..9).
package rtcc_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] REG_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_DAY   = 3'd3;
    localparam logic [ADDR_W-1:0] REG_WDAY  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_MONTH = 3'd5;
    localparam logic [ADDR_W-1:0] REG_YEAR  = 3'd6;

    // Add one to a two-digit BCD value (no wrap handling at 99).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // True when the BCD year is a multiple of four (00 included).
    function automatic logic year_is_leap(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last BCD day of a BCD month.
    function automatic logic [5:0] month_last_day(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtcc_prescaler.sv
// Divides the tick input down to one pulse per second.
// Assumes tick_in is a single-cycle pulse. A stop request parks the count
// at zero; the pulse fires at mid-count so the first second after release
// comes after half a period, then every full period.
module rtcc_prescaler #(
    parameter int TICKS_PER_SEC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic stop,
    output logic sec_pulse
);
    localparam int CNT_W = $clog2(TICKS_PER_SEC);
    localparam logic [CNT_W-1:0] FIRE_AT = CNT_W'(TICKS_PER_SEC / 2 - 1);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count ticks, wrap at the period, hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (stop)
            cnt_q <= '0;
        else if (tick_in)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Emit the second pulse on the mid-count tick.
    assign sec_pulse = tick_in && !stop && (cnt_q == FIRE_AT);

    assert_stop_quiets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sec_pulse);

endmodule

// File: rtl/rtcc_catchup.sv
// Holds second pulses while an access is active and releases them later.
// Assumes an access lasts well under one second, so a small pending count
// is enough. A write also holds the release for that cycle.
module rtcc_catchup #(
    parameter int PEND_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_pulse,
    input  logic busy,
    input  logic hold,
    output logic step
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [PEND_W-1:0] pend_q;

    // Release one owed second per cycle when the bus is idle.
    assign step = (pend_q != '0) && !busy && !hold;

    // Track owed seconds: add new pulses, subtract released ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= pend_q + {{(PEND_W-1){1'b0}}, sec_pulse}
                             - {{(PEND_W-1){1'b0}}, step};
    end

    assert_pending_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == PEND_MAX) |-> !sec_pulse);

endmodule

// File: rtl/rtcc_calendar.sv
// Time and calendar registers with BCD carry chain and register writes.
// Assumes written values are valid BCD; a write takes priority over a step
// in the same cycle (the caller holds the step back in that case).
module rtcc_calendar
    import rtcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              supply_low,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [6:0]        sec_o,
    output logic [6:0]        min_o,
    output logic [5:0]        hour_o,
    output logic [5:0]        day_o,
    output logic [2:0]        wday_o,
    output logic [4:0]        month_o,
    output logic              century_o,
    output logic [7:0]        year_o,
    output logic              vlow_o
);
    logic [6:0] sec_q, min_q;
    logic [5:0] hour_q, day_q;
    logic [2:0] wday_q;
    logic [4:0] month_q;
    logic [7:0] year_q;
    logic       century_q, vlow_q;

    logic sec_wrap, min_wrap, hour_wrap, day_wrap, month_wrap;
    logic c_min, c_hour, c_day, c_month, c_year;

    // Decide which fields are at their upper limit.
    always_comb begin
        sec_wrap   = sec_q >= 7'h59;
        min_wrap   = min_q >= 7'h59;
        hour_wrap  = hour_q >= 6'h23;
        day_wrap   = day_q >= month_last_day(month_q, year_is_leap(year_q));
        month_wrap = month_q >= 5'h12;
        c_min      = step && sec_wrap;
        c_hour     = c_min && min_wrap;
        c_day      = c_hour && hour_wrap;
        c_month    = c_day && day_wrap;
        c_year     = c_month && month_wrap;
    end

    // Load written fields, otherwise ripple one second through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q     <= '0;
            min_q     <= '0;
            hour_q    <= '0;
            day_q     <= 6'h01;
            wday_q    <= '0;
            month_q   <= 5'h01;
            century_q <= 1'b0;
            year_q    <= '0;
            vlow_q    <= 1'b1;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    REG_SEC:   begin sec_q <= wr_data[6:0]; vlow_q <= wr_data[7]; end
                    REG_MIN:   min_q  <= wr_data[6:0];
                    REG_HOUR:  hour_q <= wr_data[5:0];
                    REG_DAY:   day_q  <= wr_data[5:0];
                    REG_WDAY:  wday_q <= wr_data[2:0];
                    REG_MONTH: begin month_q <= wr_data[4:0]; century_q <= wr_data[7]; end
                    REG_YEAR:  year_q <= wr_data;
                    default:   ;
                endcase
            end else if (step) begin
                sec_q <= sec_wrap ? '0 : 7'(bcd_inc({1'b0, sec_q}));
                if (c_min)
                    min_q <= min_wrap ? '0 : 7'(bcd_inc({1'b0, min_q}));
                if (c_hour)
                    hour_q <= hour_wrap ? '0 : 6'(bcd_inc({2'b00, hour_q}));
                if (c_day) begin
                    day_q  <= day_wrap ? 6'h01 : 6'(bcd_inc({2'b00, day_q}));
                    wday_q <= (wday_q >= 3'd6) ? '0 : wday_q + 3'd1;
                end
                if (c_month)
                    month_q <= month_wrap ? 5'h01 : 5'(bcd_inc({3'b000, month_q}));
                if (c_year) begin
                    year_q <= (year_q >= 8'h99) ? '0 : bcd_inc(year_q);
                    if (year_q >= 8'h99)
                        century_q <= ~century_q;
                end
            end
            if (supply_low)
                vlow_q <= 1'b1;
        end
    end

    assign sec_o     = sec_q;
    assign min_o     = min_q;
    assign hour_o    = hour_q;
    assign day_o     = day_q;
    assign wday_o    = wday_q;
    assign month_o   = month_q;
    assign century_o = century_q;
    assign year_o    = year_q;
    assign vlow_o    = vlow_q;

    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && sec_q == 7'h59) |=> (sec_q == 7'h00));

    assert_century_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_year && !wr_en && year_q == 8'h99) |=> (century_q != $past(century_q)));

    assert_vlow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vlow_q && !(wr_en && wr_addr == REG_SEC)) |=> vlow_q);

endmodule

// File: rtl/rtcc_clock_calendar.sv
// Top of the clock calendar: prescaler, freeze/catch-up and calendar core,
// plus the read multiplexer. Assumes the bus keeps access_busy high for
// less than one second at a time.
module rtcc_clock_calendar
    import rtcc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 64,
    parameter int PEND_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              presc_stop,
    input  logic              supply_low,
    input  logic              access_busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic       sec_pulse, step;
    logic [6:0] sec_f, min_f;
    logic [5:0] hour_f, day_f;
    logic [2:0] wday_f;
    logic [4:0] month_f;
    logic [7:0] year_f;
    logic       century_f, vlow_f;

    rtcc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .stop(presc_stop),
        .sec_pulse(sec_pulse)
    );

    rtcc_catchup #(.PEND_W(PEND_W)) u_catch (
        .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .busy(access_busy),
        .hold(wr_en), .step(step)
    );

    rtcc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .step(step), .supply_low(supply_low),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_o(sec_f), .min_o(min_f), .hour_o(hour_f), .day_o(day_f),
        .wday_o(wday_f), .month_o(month_f), .century_o(century_f),
        .year_o(year_f), .vlow_o(vlow_f)
    );

    // Assemble the addressed register with unimplemented bits at zero.
    always_comb begin
        case (rd_addr)
            REG_SEC:   rd_data = {vlow_f, sec_f};
            REG_MIN:   rd_data = {1'b0, min_f};
            REG_HOUR:  rd_data = {2'b00, hour_f};
            REG_DAY:   rd_data = {2'b00, day_f};
            REG_WDAY:  rd_data = {5'b00000, wday_f};
            REG_MONTH: rd_data = {century_f, 2'b00, month_f};
            REG_YEAR:  rd_data = year_f;
            default:   rd_data = 8'h00;
        endcase
    end

    assert_frozen_seconds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (access_busy && !wr_en) |=> $stable(sec_f));

endmodule

// File: tb/rtcc_clock_calendar_tb_top.sv
`timescale 1ns/1ps
module rtcc_clock_calendar_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       presc_stop = 1'b0;
    logic       supply_low = 1'b0;
    logic       access_busy = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_busy = 1'b0;

    typedef struct {
        logic [2:0] addr;
        logic [7:0] value;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    rtcc_clock_calendar dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .presc_stop(presc_stop),
        .supply_low(supply_low), .access_busy(access_busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Monitor: pop expected items and compare against the read port.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t item;
                mon_busy = 1'b1;
                item = sb.pop_front();
                rd_addr = item.addr;
                #1;
                checks++;
                if (rd_data !== item.value) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%02h expected=%02h",
                             item.tag, item.addr, rd_data, item.value);
                end
                mon_busy = 1'b0;
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] v, input string tag);
        exp_t item;
        item.addr = a; item.value = v; item.tag = tag;
        sb.push_back(item);
        wait (sb.size() == 0);
        wait (!mon_busy);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_pulse();
        @(negedge clk); presc_stop = 1'b1;
        @(negedge clk); presc_stop = 1'b0;
    endtask

    // Restart the prescaler and let exactly one second elapse.
    task automatic one_second();
        stop_pulse();
        give_ticks(32);
        settle(3);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        write_reg(3'd2, h);
        write_reg(3'd1, m);
        write_reg(3'd0, s);
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: scenarios per requirement.
    initial begin
        settle(4);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state, R12 address 7 reads zero
        expect_reg(3'd0, 8'h80, "R1 sec");
        expect_reg(3'd1, 8'h00, "R1 min");
        expect_reg(3'd2, 8'h00, "R1 hour");
        expect_reg(3'd3, 8'h01, "R1 day");
        expect_reg(3'd4, 8'h00, "R1 wday");
        expect_reg(3'd5, 8'h01, "R1 month");
        expect_reg(3'd6, 8'h00, "R1 year");
        expect_reg(3'd7, 8'h00, "R12 addr7");

        // R10 clear flag by writing seconds with bit 7 low
        write_reg(3'd0, 8'h00);
        expect_reg(3'd0, 8'h00, "R10 clear");

        // R3 half-period first second, R2 full period after
        stop_pulse();
        give_ticks(31); settle(3);
        expect_reg(3'd0, 8'h00, "R3 31 ticks");
        give_ticks(1); settle(3);
        expect_reg(3'd0, 8'h01, "R3 32 ticks");
        give_ticks(63); settle(3);
        expect_reg(3'd0, 8'h01, "R2 63 ticks");
        give_ticks(1); settle(3);
        expect_reg(3'd0, 8'h02, "R2 64 ticks");

        // R4 seconds and minutes rollover
        set_time(8'h22, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd0, 8'h00, "R4 sec");
        expect_reg(3'd1, 8'h00, "R4 min");
        expect_reg(3'd2, 8'h23, "R4 hour");

        // R5 hour rollover, R6 weekday wrap 6->0 then 0->1
        write_reg(3'd3, 8'h15);
        write_reg(3'd5, 8'h03);
        write_reg(3'd4, 8'h06);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd2, 8'h00, "R5 hour");
        expect_reg(3'd3, 8'h16, "R5 day");
        expect_reg(3'd4, 8'h00, "R6 wrap");
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd3, 8'h17, "R5 day again");
        expect_reg(3'd4, 8'h01, "R6 advance");

        // R7 30-day and 31-day months
        write_reg(3'd5, 8'h04);
        write_reg(3'd3, 8'h30);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd3, 8'h01, "R7 april end");
        expect_reg(3'd5, 8'h05, "R7 to may");
        write_reg(3'd3, 8'h30);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd3, 8'h31, "R7 may 31");
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd3, 8'h01, "R7 may end");
        expect_reg(3'd5, 8'h06, "R7 to june");

        // R8 February in leap and common years
        write_reg(3'd6, 8'h24);
        write_reg(3'd5, 8'h02);
        write_reg(3'd3, 8'h28);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd3, 8'h29, "R8 year 24");
        write_reg(3'd6, 8'h23);
        write_reg(3'd5, 8'h02);
        write_reg(3'd3, 8'h28);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd3, 8'h01, "R8 year 23 day");
        expect_reg(3'd5, 8'h03, "R8 year 23 month");
        write_reg(3'd6, 8'h00);
        write_reg(3'd5, 8'h02);
        write_reg(3'd3, 8'h28);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd3, 8'h29, "R8 year 00");
        write_reg(3'd6, 8'h12);
        write_reg(3'd5, 8'h02);
        write_reg(3'd3, 8'h28);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd3, 8'h29, "R8 year 12");

        // R9 year increment, 99 rollover and century toggle both ways
        write_reg(3'd6, 8'h19);
        write_reg(3'd5, 8'h12);
        write_reg(3'd3, 8'h31);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd6, 8'h20, "R9 year inc");
        expect_reg(3'd5, 8'h01, "R9 jan");
        write_reg(3'd6, 8'h99);
        write_reg(3'd5, 8'h12);
        write_reg(3'd3, 8'h31);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd6, 8'h00, "R9 year wrap");
        expect_reg(3'd5, 8'h81, "R9 century set");
        expect_reg(3'd3, 8'h01, "R9 day");
        write_reg(3'd6, 8'h99);
        write_reg(3'd5, 8'h92);
        write_reg(3'd3, 8'h31);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        expect_reg(3'd5, 8'h01, "R9 century clear");

        // R10 sticky supply-low flag
        write_reg(3'd0, 8'h05);
        @(negedge clk); supply_low = 1'b1;
        @(negedge clk); supply_low = 1'b0;
        settle(1);
        expect_reg(3'd0, 8'h85, "R10 set");
        write_reg(3'd1, 8'h10);
        expect_reg(3'd0, 8'h85, "R10 other write");
        write_reg(3'd0, 8'h07);
        expect_reg(3'd0, 8'h07, "R10 cleared");

        // R11 freeze during access, catch up afterwards
        write_reg(3'd0, 8'h10);
        @(negedge clk); access_busy = 1'b1;
        one_second();
        expect_reg(3'd0, 8'h10, "R11 frozen");
        @(negedge clk); access_busy = 1'b0;
        settle(3);
        expect_reg(3'd0, 8'h11, "R11 caught up");

        // R12 unimplemented bits and address 7
        write_reg(3'd4, 8'hFF);
        expect_reg(3'd4, 8'h07, "R12 wday mask");
        write_reg(3'd2, 8'hFF);
        expect_reg(3'd2, 8'h3F, "R12 hour mask");
        write_reg(3'd1, 8'hFF);
        expect_reg(3'd1, 8'h7F, "R12 min mask");
        write_reg(3'd5, 8'h7F);
        expect_reg(3'd5, 8'h1F, "R12 month mask");
        write_reg(3'd6, 8'h42);
        expect_reg(3'd6, 8'h42, "R12 year load");
        write_reg(3'd7, 8'hAA);
        expect_reg(3'd7, 8'h00, "R12 addr7 write");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule